// File: doc/BRIEF.md
# Capture, Compare and PWM Channel

This block is a single timer channel that serves three purposes selected by a 4-bit mode code. In capture mode it watches an input pin and stores a snapshot of a free-running 16-bit timer when the chosen kind of edge arrives. Rising edges can optionally be divided by 4 or by 16 before they count. In compare mode it watches for the 16-bit timer reaching a programmed value. On that match it sets the output pin high, clears it, raises only a flag, or issues a trigger. The trigger resets the timer and can start an analog-to-digital conversion.

In PWM mode the channel produces a pulse whose width has 10-bit resolution. It compares the duty value against an 8-bit period timer extended by two sub-count bits. A new duty value takes effect only at a period boundary. The timers and the converter live outside the block: their counts, the period-match pulse and the converter enable arrive as inputs, and the timer reset and conversion start leave as outputs.

Top module: `ccp_unit`

## Requirements
- R1: After reset pin_o, capture_o, irq_o, adc_start_o and tmr_rst_o are all 0.
- R2: Mode 4'b0100 captures on a falling edge of pin_i and mode 4'b0101 on a rising edge. The capture uses tmr16_i as sampled at the clock edge that sees the new pin level. From the next cycle capture_o holds that value and irq_o is 1 for exactly one cycle. In all other modes capture_o keeps its value.
- R3: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th rising edge. Rising edges in between change neither capture_o nor irq_o.
- R4: A change of mode code clears the edge divider, so counting restarts from zero in the new capture mode.
- R5: Mode 4'b1000 drives pin_o low from the cycle after the mode is entered. pin_o goes high in the cycle after tmr16_i first becomes equal to value_i. Equality that persists over several cycles gives only one event, and each event pulses irq_o for one cycle.
- R6: Mode 4'b1001 drives pin_o high from the cycle after the mode is entered. pin_o goes low, with an irq_o pulse, on a match.
- R7: Mode 4'b1010 pulses irq_o on a match and leaves pin_o unchanged.
- R8: Mode 4'b1011 on a match pulses tmr_rst_o and irq_o for one cycle. adc_start_o pulses in that same cycle only when adc_en_i is 1. pin_o is unchanged.
- R9: In modes 4'b11xx, pin_o is 1 exactly while {tmr8_i, tmr8_sub_i} is less than the active 10-bit duty. That duty has value_i[7:0] as its upper 8 bits and duty_lo_i as its lower 2 bits. A duty of 0 keeps pin_o low.
- R10: The active duty is loaded only at a clock edge where per_match_i is 1, and it is 0 after reset. A duty written mid-period has no effect until the next period match.
- R11: Mode 4'b0000 forces pin_o low from the cycle after it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Mode code |
| duty_lo_i | input | 2 | Lowest two bits of the PWM duty |
| value_i | input | 16 | Compare value; bits 7:0 are the upper duty bits in PWM |
| tmr16_i | input | 16 | Free-running 16-bit timer count |
| tmr8_i | input | 8 | Period timer count |
| tmr8_sub_i | input | 2 | Sub-count bits extending the period timer |
| per_match_i | input | 1 | Period timer reached its period this cycle |
| adc_en_i | input | 1 | Converter enabled |
| pin_i | input | 1 | Channel pin input |
| pin_o | output | 1 | Channel pin output |
| capture_o | output | 16 | Captured timer value |
| irq_o | output | 1 | One-cycle capture/compare event pulse |
| adc_start_o | output | 1 | Conversion start pulse |
| tmr_rst_o | output | 1 | Request to reset the 16-bit timer |

## Verification
Two situations are hard to reach. The first is the divider state left behind when the mode code moves between capture modes. The bench leaves the divide-by-4 count partly advanced, swaps to the divide-by-16 mode and back, and then requires a full four fresh edges before a capture. The second is the duty buffer. The bench sweeps every duty from 0 to beyond full scale over a short period, writing each new value just after a period match. This proves that the old duty governs every sub-count of the following period and the new one the period after.

// File: rtl/ccp_unit.sv
module ccp_unit #(
  parameter int TW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    duty_lo_i,
  input  logic [TW-1:0] value_i,
  input  logic [TW-1:0] tmr16_i,
  input  logic [PW-1:0] tmr8_i,
  input  logic [1:0]    tmr8_sub_i,
  input  logic          per_match_i,
  input  logic          adc_en_i,
  input  logic          pin_i,
  output logic          pin_o,
  output logic [TW-1:0] capture_o,
  output logic          irq_o,
  output logic          adc_start_o,
  output logic          tmr_rst_o
);
  localparam int DW = PW + 2;
  localparam logic [3:0] M_OFF = 4'b0000;
  localparam logic [3:0] M_SET = 4'b1000;
  localparam logic [3:0] M_CLR = 4'b1001;
  localparam logic [3:0] M_TRG = 4'b1011;

  logic [3:0]    mode_q;
  logic          pin_s, eq_q, out_q;
  logic [3:0]    pcnt, plim;
  logic [DW-1:0] duty_act;

  wire mode_chg = mode_q != mode_i;
  wire is_cap   = mode_i[3:2] == 2'b01;
  wire is_cmp   = mode_i[3:2] == 2'b10;
  wire is_pwm   = &mode_i[3:2];
  wire rise     = pin_i & ~pin_s;
  wire fall     = ~pin_i & pin_s;
  wire edge_ok  = (mode_i[1:0] == 2'b00) ? fall : rise;
  wire cap_ev   = is_cap & ~mode_chg & edge_ok & (pcnt == plim);
  wire eq       = tmr16_i == value_i;
  wire hit      = is_cmp & ~mode_chg & eq & ~eq_q;

  always_comb begin
    case (mode_i[1:0])
      2'b10:   plim = 4'd3;
      2'b11:   plim = 4'd15;
      default: plim = 4'd0;
    endcase
  end

  assign pin_o = is_pwm ? ({tmr8_i, tmr8_sub_i} < duty_act) : out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= M_OFF;
      pin_s       <= 1'b0;
      eq_q        <= 1'b0;
      out_q       <= 1'b0;
      pcnt        <= '0;
      duty_act    <= '0;
      capture_o   <= '0;
      irq_o       <= 1'b0;
      adc_start_o <= 1'b0;
      tmr_rst_o   <= 1'b0;
    end else begin
      mode_q      <= mode_i;
      pin_s       <= pin_i;
      eq_q        <= eq;
      irq_o       <= cap_ev | hit;
      tmr_rst_o   <= hit & (mode_i == M_TRG);
      adc_start_o <= hit & (mode_i == M_TRG) & adc_en_i;
      if (cap_ev) capture_o <= tmr16_i;
      if (mode_chg || !is_cap) pcnt <= '0;
      else if (edge_ok) pcnt <= (pcnt == plim) ? 4'd0 : pcnt + 4'd1;
      if (per_match_i) duty_act <= {value_i[PW-1:0], duty_lo_i};
      if (mode_i == M_OFF) out_q <= 1'b0;
      else if (mode_chg && mode_i == M_SET) out_q <= 1'b0;
      else if (mode_chg && mode_i == M_CLR) out_q <= 1'b1;
      else if (hit && mode_i == M_SET) out_q <= 1'b1;
      else if (hit && mode_i == M_CLR) out_q <= 1'b0;
    end
  end

  a_r8_trig_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start_o || tmr_rst_o) |-> $past(mode_i) == M_TRG);
  a_r8_adc_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |-> tmr_rst_o);
  a_r10_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(per_match_i) |-> $stable(duty_act));
  a_r2_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i[3:2]) != 2'b01) |-> $stable(capture_o));
  a_r11_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == M_OFF && mode_i == M_OFF) |-> !pin_o);
endmodule

// File: tb/ccp_unit_test.sv
module ccp_unit_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] mode = 0;
  logic [1:0] dlo = 0, sub = 0;
  logic [15:0] val = 0, t16 = 0;
  logic [7:0] t8 = 0;
  logic pm = 0, aen = 0, pin = 0;
  logic pin_o, irq, adc, trst;
  logic [15:0] cap;
  int checks = 0, fails = 0;
  logic [15:0] exp_cap;

  ccp_unit uut (.clk(clk), .rst_n(rst_n), .mode_i(mode), .duty_lo_i(dlo),
    .value_i(val), .tmr16_i(t16), .tmr8_i(t8), .tmr8_sub_i(sub),
    .per_match_i(pm), .adc_en_i(aen), .pin_i(pin), .pin_o(pin_o),
    .capture_o(cap), .irq_o(irq), .adc_start_o(adc), .tmr_rst_o(trst));

  always #(CLK_P/2) clk = ~clk;

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cap(input string tag, input bit ev);
    chk(cap == exp_cap, {tag, " capture"}, cap, exp_cap);
    chk(irq == ev, {tag, " irq"}, irq, ev);
  endtask

  task automatic rise_edge(input logic [15:0] tv, input bit ev, input string tag);
    t16 = tv; pin = 1; step();
    if (ev) exp_cap = tv;
    chk_cap(tag, ev);
    pin = 0; step();
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_cap = 0;
    @(negedge clk); step(); step();
    rst_n = 1; step();
    // R1 reset state
    chk(pin_o == 0 && cap == 0 && irq == 0 && adc == 0 && trst == 0, "R1 reset", {pin_o, irq, adc, trst}, 0);

    // R2 falling edge capture
    mode = 4'b0100; step();
    pin = 1; t16 = 16'h1111; step();
    chk_cap("R2 fall-mode rising ignored", 0);
    t16 = 16'hA5A5; pin = 0; step();
    exp_cap = 16'hA5A5;
    chk_cap("R2 fall capture", 1);
    step();
    chk_cap("R2 irq one cycle", 0);
    // R2 rising edge capture
    mode = 4'b0101; step();
    rise_edge(16'h3C3C, 1, "R2 rise capture");
    chk_cap("R2 rise-mode falling ignored", 0);

    // R3 divide by 4 and 16
    mode = 4'b0110; step();
    for (int i = 0; i < 8; i++) rise_edge(16'h0100 + 16'(i), (i % 4) == 3, "R3 every 4th");
    mode = 4'b0111; step();
    for (int i = 0; i < 32; i++) rise_edge(16'h0200 + 16'(i), (i % 16) == 15, "R3 every 16th");

    // R4 mode change clears divider
    mode = 4'b0110; step();
    rise_edge(16'h0301, 0, "R4 pre");
    rise_edge(16'h0302, 0, "R4 pre");
    mode = 4'b0111; step();
    mode = 4'b0110; step();
    for (int i = 0; i < 4; i++) rise_edge(16'h0400 + 16'(i), i == 3, "R4 restart");

    // R5 set on match
    val = 16'h1234; t16 = 0; mode = 4'b1000; step();
    chk(pin_o == 0, "R5 entry low", pin_o, 0);
    t16 = 16'h1234; step();
    chk(pin_o == 1 && irq == 1, "R5 match", {pin_o, irq}, 2'b11);
    step();
    chk(irq == 0 && pin_o == 1, "R5 held equality one event", {pin_o, irq}, 2'b10);
    chk(cap == exp_cap, "R2 compare leaves capture", cap, exp_cap);
    t16 = 16'h1235; step();
    chk(pin_o == 1, "R5 stays high", pin_o, 1);

    // R6 clear on match
    mode = 4'b1001; step();
    chk(pin_o == 1, "R6 entry high", pin_o, 1);
    t16 = 16'h1234; step();
    chk(pin_o == 0 && irq == 1, "R6 match", {pin_o, irq}, 2'b01);

    // R7 flag only
    mode = 4'b1010; t16 = 0; step();
    chk(pin_o == 0, "R7 pin kept", pin_o, 0);
    t16 = 16'h1234; step();
    chk(pin_o == 0 && irq == 1 && trst == 0, "R7 match", {pin_o, irq, trst}, 3'b010);

    // R8 trigger, converter disabled then enabled
    mode = 4'b1011; t16 = 0; aen = 0; step();
    t16 = 16'h1234; step();
    chk(trst == 1 && adc == 0 && irq == 1 && pin_o == 0, "R8 trig no adc", {trst, adc, irq, pin_o}, 4'b1010);
    step();
    chk(trst == 0 && irq == 0, "R8 one cycle", {trst, irq}, 0);
    t16 = 0; aen = 1; step();
    t16 = 16'h1234; step();
    chk(trst == 1 && adc == 1 && irq == 1, "R8 trig with adc", {trst, adc, irq}, 3'b111);
    step();
    chk(adc == 0, "R8 adc one cycle", adc, 0);

    // R9/R10 PWM sweep, period 3 -> count 0..15
    mode = 4'b1100; step();
    begin
      int act;
      act = 0;
      for (int d = 0; d <= 17; d++) begin
        val = 16'(d >> 2); dlo = 2'(d & 3);
        for (int p = 0; p < 2; p++)
          for (int t = 0; t < 4; t++)
            for (int s = 0; s < 4; s++) begin
              t8 = 8'(t); sub = 2'(s); pm = (t == 3 && s == 3);
              #1;
              chk(pin_o == ((t * 4 + s) < act), p == 0 ? "R10 old duty held" : "R9 pwm level",
                  pin_o, (t * 4 + s) < act);
              step();
              if (pm) act = d;
            end
      end
      pm = 0;
      // R11 off forces low (duty 17 leaves pin high)
      t8 = 0; sub = 0; #1;
      chk(pin_o == 1, "R9 full duty high", pin_o, 1);
      mode = 4'b0000; step(); step();
      chk(pin_o == 0, "R11 off low", pin_o, 0);
      mode = 4'b1000; step();
      mode = 4'b1001; step();
      chk(pin_o == 1, "R6 re-entry high", pin_o, 1);
      mode = 4'b0000; step();
      chk(pin_o == 0, "R11 off clears compare pin", pin_o, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule